// File: doc/BRIEF.md
# Strobe-Handshake Register Bus Slave

This block lets an external microprocessor with an asynchronous, strobe-driven bus reach a small bank of 16-bit registers inside a clocked design. The host drops the address strobe, presents a 15-bit address and releases the strobe. The slave latches the address on that rising edge. The host then picks read or write, lowers the data strobe and waits for the slave's acknowledge. On a write, the host raises the data strobe to hand over the data. On a read, the host samples the data bus while the acknowledge is high.

Every control pin reaches the clock domain through a two-flop synchronizer, and every strobe edge is found on the synchronized copy. The address and data pins pass through a matching delay line, so each captured value lines up with the strobe sample that selects it. A byte-select pin turns a write into a byte transfer, which updates only the low eight bits. The acknowledge is held back for a parameterized number of setup cycles, so a write is committed only after the host has seen the acknowledge.

Top module: `strobe_bus_slave`

## Requirements
- R1: After reset the acknowledge output is 0, the data bus is released (high impedance) and every register reads as 0x0000.
- R2: The address is latched on the rising edge of the address strobe while chip select is low. Later read and write cycles use the latched address until the next such edge.
- R3: While chip select is high, the slave ignores both strobes: an address strobe pulse leaves the latched address unchanged, and a data strobe fall raises no acknowledge.
- R4: With chip select low, the acknowledge rises exactly SETUP_CYC+3 clock edges after the data strobe falls (two synchronizer edges, one detection edge and SETUP_CYC setup edges).
- R5: In a write cycle (rw = 0), a data strobe rise after the acknowledge stores the data bus in the addressed register. The acknowledge falls 3 clock edges after that rise.
- R6: If the data strobe rises before the acknowledge is raised, the cycle aborts: no acknowledge is raised and no register changes.
- R7: If chip select is released while the acknowledge is high, the acknowledge falls 3 clock edges later and no write takes place.
- R8: A write with byte_sel = 1 updates only bits 7:0 of the register. Bits 15:8 keep their value. With byte_sel = 0, all 16 bits are written.
- R9: In a read cycle (rw = 1), the slave drives the addressed register onto the data bus only while chip select and the data strobe are both low. At all other times the bus is high impedance.
- R10: Addresses at or above REG_COUNT select no register. Writes to them are dropped and reads from them return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Address strobe, active low; its rising edge latches the address |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_ds_n | input | 1 | Data strobe, active low; marks the data phase |
| bus_byte | input | 1 | 1 = byte write (bits 7:0 only), 0 = word write |
| bus_addr | input | ADDR_W (15) | Register address |
| bus_data | inout | DATA_W (16) | Bidirectional data bus |
| bus_ack | output | 1 | Data acknowledge / ready, active high |

## Verification
The bench builds the slave with REG_COUNT = 8 and SETUP_CYC = 5. With 8 registers, an address such as 9 falls outside the bank while its low index bits alias register 1, so an out-of-range write that wrongly wrapped would show up on a read of register 1. A five-cycle setup opens a wide window before the acknowledge. This makes the exact acknowledge edge measurable and leaves room for a data strobe that rises early and aborts the cycle. The bench also tests a chip-select release while the acknowledge is high.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACK   = 2'd2
  } cyc_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sbs_cycle_fsm.sv
module sbs_cycle_fsm
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SETUP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n_s,
  input  logic              cs_n_s,
  input  logic              ds_n_s,
  input  logic              rw_s,
  input  logic [ADDR_W-1:0] addr_al,
  input  logic [DATA_W-1:0] wdata_al,
  input  logic              byte_al,
  output logic              ack,
  output logic              oe,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_stb,
  output logic              wr_byte,
  output logic [DATA_W-1:0] wr_data
);

  localparam int unsigned CNT_W = $clog2(SETUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

  cyc_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             as_p;
  logic             ds_p;
  logic             rw_q;

  logic as_rise;
  logic ds_fall;
  logic ds_rise;

  always_comb begin
    as_rise = !as_p && as_n_s;
    ds_fall = ds_p && !ds_n_s;
    ds_rise = !ds_p && ds_n_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      as_p    <= 1'b1;
      ds_p    <= 1'b1;
      rw_q    <= 1'b1;
      ack     <= 1'b0;
      oe      <= 1'b0;
      addr_q  <= '0;
      wr_stb  <= 1'b0;
      wr_byte <= 1'b0;
      wr_data <= '0;
    end else begin
      as_p   <= as_n_s;
      ds_p   <= ds_n_s;
      wr_stb <= 1'b0;
      oe     <= !cs_n_s && !ds_n_s && rw_s;
      if (as_rise && !cs_n_s) addr_q <= addr_al;
      case (state)
        ST_IDLE: begin
          if (ds_fall && !cs_n_s) begin
            state <= ST_SETUP;
            cnt   <= '0;
            rw_q  <= rw_s;
          end
        end
        ST_SETUP: begin
          if (cs_n_s || ds_rise) begin
            state <= ST_IDLE;
          end else if (cnt == CNT_LAST) begin
            state <= ST_ACK;
            ack   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (cs_n_s) begin
            state <= ST_IDLE;
            ack   <= 1'b0;
          end else if (ds_rise) begin
            state <= ST_IDLE;
            ack   <= 1'b0;
            if (!rw_q) begin
              wr_stb  <= 1'b1;
              wr_byte <= byte_al;
              wr_data <= wdata_al;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: acknowledge only rises at the end of a full setup count
  a_r4_ack_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(state) == ST_SETUP && $past(cnt) == CNT_LAST));

  // R5: a data strobe rise during acknowledge drops it next cycle
  a_r5_ds_rise_drops_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && ds_rise) |=> !ack);

  // R7: chip select release during acknowledge drops it next cycle
  a_r7_cs_release_drops_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && cs_n_s) |=> (!ack && !wr_stb));

  // R3: an unselected slave never leaves idle
  a_r3_unselected_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cs_n_s) |=> (state == ST_IDLE));

  // R6: no write strobe unless the acknowledge was up
  a_r6_write_needs_ack: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(ack));

endmodule

// File: rtl/sbs_reg_bank.sv
module sbs_reg_bank
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic             wr_in_range;
  logic             rd_in_range;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    wr_in_range = (wr_addr < ADDR_W'(REG_COUNT));
    rd_in_range = (rd_addr < ADDR_W'(REG_COUNT));
    wr_idx      = wr_addr[IDX_W-1:0];
    rd_idx      = rd_addr[IDX_W-1:0];
  end

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      logic [BYTE_W-1:0] mem [REG_COUNT];
      logic              lane_we;

      if (ln == 0) begin : g_low
        assign lane_we = wr_en && wr_in_range;
      end else begin : g_high
        assign lane_we = wr_en && wr_in_range && !wr_byte;

        // R8: a byte write keeps every upper lane of the target register
        a_r8_byte_keeps_upper: assert property (@(posedge clk) disable iff (rst)
          (wr_en && wr_byte && wr_in_range) |=>
            (mem[$past(wr_idx)] == $past(mem[wr_idx])));
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
        end else if (lane_we) begin
          mem[wr_idx] <= wr_data[ln*BYTE_W +: BYTE_W];
        end
      end

      assign rd_word[ln*BYTE_W +: BYTE_W] = mem[rd_idx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (rd_in_range) rd_data <= rd_word;
    else                  rd_data <= '0;
  end

  // R10: an address outside the bank reads back as zero
  a_r10_out_of_range_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_in_range |=> (rd_data == '0));

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_as_n,
  input  logic              bus_cs_n,
  input  logic              bus_rw,
  input  logic              bus_ds_n,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_ack
);

  localparam int unsigned CTL_W   = 4;
  localparam int unsigned ALIGN   = SYNC_STG + 1;
  localparam int unsigned PAYLD_W = ADDR_W + DATA_W + 1;

  logic [CTL_W-1:0]   ctl_raw;
  logic [CTL_W-1:0]   ctl_s;
  logic [PAYLD_W-1:0] payld_raw;
  logic [PAYLD_W-1:0] payld_al;

  logic              oe;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_stb;
  logic              wr_byte;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  assign ctl_raw   = {bus_as_n, bus_cs_n, bus_ds_n, bus_rw};
  assign payld_raw = {bus_addr, bus_data, bus_byte};

  sbs_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STG),
    .RST_VAL({CTL_W{1'b1}})
  ) ctl_sync_i (
    .clk(clk),
    .rst(rst),
    .d  (ctl_raw),
    .q  (ctl_s)
  );

  sbs_sync #(
    .WIDTH  (PAYLD_W),
    .STAGES (ALIGN),
    .RST_VAL('0)
  ) payld_align_i (
    .clk(clk),
    .rst(rst),
    .d  (payld_raw),
    .q  (payld_al)
  );

  sbs_cycle_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SETUP_CYC(SETUP_CYC)
  ) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .as_n_s  (ctl_s[3]),
    .cs_n_s  (ctl_s[2]),
    .ds_n_s  (ctl_s[1]),
    .rw_s    (ctl_s[0]),
    .addr_al (payld_al[PAYLD_W-1 -: ADDR_W]),
    .wdata_al(payld_al[DATA_W:1]),
    .byte_al (payld_al[0]),
    .ack     (bus_ack),
    .oe      (oe),
    .addr_q  (addr_q),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .wr_data (wr_data)
  );

  sbs_reg_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_COUNT(REG_COUNT)
  ) bank_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_stb),
    .wr_byte(wr_byte),
    .wr_addr(addr_q),
    .wr_data(wr_data),
    .rd_addr(addr_q),
    .rd_data(rd_data)
  );

  assign bus_data = oe ? rd_data : {DATA_W{1'bz}};

  // R9: the bus is never driven while the synchronized select is inactive
  a_r9_no_drive_unselected: assert property (@(posedge clk) disable iff (rst)
    ctl_s[2] |=> !oe);

endmodule

// File: tb/strobe_bus_slave_tb_top.sv
module strobe_bus_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 15;
  localparam int DW  = 16;
  localparam int NREG = 8;
  localparam int SETUP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, cs_n = 1'b1, rw = 1'b1, ds_n = 1'b1, byte_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          tb_drv = 1'b0;
  logic [DW-1:0] tb_wdata = '0;
  wire  [DW-1:0] bus_data;
  logic          ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign bus_data = tb_drv ? tb_wdata : {DW{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_bus_slave #(
    .ADDR_W(AW), .DATA_W(DW), .REG_COUNT(NREG), .SETUP_CYC(SETUP)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_as_n(as_n), .bus_cs_n(cs_n), .bus_rw(rw),
    .bus_ds_n(ds_n), .bus_byte(byte_sel), .bus_addr(addr),
    .bus_data(bus_data), .bus_ack(ack)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic addr_phase(input logic [AW-1:0] a);
    @(negedge clk);
    as_n = 1'b0; addr = a;
    cyc(3);
    as_n = 1'b1;
    cyc(4);
  endtask

  task automatic wait_ack(output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (ack) begin got = 1; break; end
      cyc(1);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic bsel);
    bit got;
    cs_n = 1'b0;
    addr_phase(a);
    rw = 1'b0; byte_sel = bsel; tb_wdata = d; tb_drv = 1'b1;
    cyc(1);
    ds_n = 1'b0;
    wait_ack(got);
    ds_n = 1'b1;
    cyc(4);
    cs_n = 1'b1; tb_drv = 1'b0; rw = 1'b1; byte_sel = 1'b0;
    cyc(4);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit set_addr, output logic [DW-1:0] d);
    bit got;
    cs_n = 1'b0;
    if (set_addr) addr_phase(a);
    else cyc(4);
    rw = 1'b1;
    cyc(1);
    ds_n = 1'b0;
    wait_ack(got);
    cyc(1);
    d = bus_data;
    ds_n = 1'b1;
    cyc(4);
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 ack after reset", {15'd0, ack}, 16'd0);
    chk("R1 bus released after reset", bus_data, {DW{1'bz}});
    do_read(15'd0, 1, d);
    chk("R1 register 0 after reset", d, 16'h0000);
    do_read(15'd7, 1, d);
    chk("R1 register 7 after reset", d, 16'h0000);
  endtask

  task automatic t_write_timing;
    logic [DW-1:0] d;
    cs_n = 1'b0;
    addr_phase(15'd3);
    rw = 1'b0; tb_wdata = 16'h1234; tb_drv = 1'b1;
    cyc(1);
    ds_n = 1'b0;
    repeat (SETUP + 2) @(posedge clk);
    @(negedge clk);
    chk("R4 ack low one edge early", {15'd0, ack}, 16'd0);
    cyc(1);
    chk("R4 ack high at SETUP+3 edges", {15'd0, ack}, 16'd1);
    ds_n = 1'b1;
    cyc(2);
    chk("R5 ack still high two edges after rise", {15'd0, ack}, 16'd1);
    cyc(1);
    chk("R5 ack low three edges after rise", {15'd0, ack}, 16'd0);
    cyc(3);
    cs_n = 1'b1; tb_drv = 1'b0; rw = 1'b1;
    cyc(4);
    do_read(15'd3, 1, d);
    chk("R5 written word read back", d, 16'h1234);
  endtask

  task automatic t_read_drive;
    bit got;
    cs_n = 1'b0;
    addr_phase(15'd3);
    rw = 1'b1;
    cyc(3);
    chk("R9 bus released before data strobe", bus_data, {DW{1'bz}});
    ds_n = 1'b0;
    wait_ack(got);
    chk("R9 bus driven during read", bus_data, 16'h1234);
    ds_n = 1'b1;
    cyc(5);
    chk("R9 bus released after data strobe", bus_data, {DW{1'bz}});
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_walk;
    logic [DW-1:0] d;
    for (int i = 0; i < NREG; i++) do_write(AW'(i), 16'hA000 + DW'(i * 16'h0111), 0);
    for (int i = NREG - 1; i >= 0; i--) begin
      do_read(AW'(i), 1, d);
      chk("R2 per-address readback", d, 16'hA000 + DW'(i * 16'h0111));
    end
    do_write(15'd3, 16'h1234, 0);
  endtask

  task automatic t_byte;
    logic [DW-1:0] d;
    do_write(15'd5, 16'hABCD, 0);
    do_write(15'd5, 16'hFF12, 1);
    do_read(15'd5, 1, d);
    chk("R8 byte write keeps upper bits", d, 16'hAB12);
    do_write(15'd5, 16'h5566, 0);
    do_read(15'd5, 1, d);
    chk("R8 word write replaces all bits", d, 16'h5566);
  endtask

  task automatic t_abort;
    logic [DW-1:0] d;
    bit seen = 0;
    do_write(15'd6, 16'hA5A5, 0);
    cs_n = 1'b0;
    addr_phase(15'd6);
    rw = 1'b0; tb_wdata = 16'h0F0F; tb_drv = 1'b1;
    cyc(1);
    ds_n = 1'b0;
    cyc(2);
    ds_n = 1'b1;
    for (int i = 0; i < SETUP + 8; i++) begin
      if (ack) seen = 1;
      cyc(1);
    end
    chk("R6 no ack on early strobe rise", {15'd0, seen}, 16'd0);
    cs_n = 1'b1; tb_drv = 1'b0; rw = 1'b1;
    cyc(4);
    do_read(15'd6, 1, d);
    chk("R6 register kept after abort", d, 16'hA5A5);
  endtask

  task automatic t_cs_release;
    logic [DW-1:0] d;
    bit got;
    cs_n = 1'b0;
    addr_phase(15'd6);
    rw = 1'b0; tb_wdata = 16'h1111; tb_drv = 1'b1;
    cyc(1);
    ds_n = 1'b0;
    wait_ack(got);
    chk("R7 ack reached before release", {15'd0, got}, 16'd1);
    cs_n = 1'b1;
    cyc(2);
    chk("R7 ack still high two edges after release", {15'd0, ack}, 16'd1);
    cyc(1);
    chk("R7 ack low three edges after release", {15'd0, ack}, 16'd0);
    ds_n = 1'b1;
    cyc(6);
    tb_drv = 1'b0; rw = 1'b1;
    do_read(15'd6, 1, d);
    chk("R7 no write after select release", d, 16'hA5A5);
  endtask

  task automatic t_unselected;
    logic [DW-1:0] d;
    bit seen = 0;
    do_read(15'd3, 1, d);
    chk("R2 latch address 3", d, 16'h1234);
    cs_n = 1'b1;
    addr_phase(15'd5);
    rw = 1'b1;
    ds_n = 1'b0;
    for (int i = 0; i < SETUP + 8; i++) begin
      if (ack) seen = 1;
      cyc(1);
    end
    ds_n = 1'b1;
    cyc(4);
    chk("R3 no ack while unselected", {15'd0, seen}, 16'd0);
    do_read(15'd0, 0, d);
    chk("R3 address kept through unselected strobe", d, 16'h1234);
  endtask

  task automatic t_range;
    logic [DW-1:0] d;
    do_write(15'd9, 16'h7777, 0);
    do_read(15'd9, 1, d);
    chk("R10 out-of-range read is zero", d, 16'h0000);
    do_read(15'd1, 1, d);
    chk("R10 aliased register untouched", d, 16'hA111);
    do_read(15'h7FFF, 1, d);
    chk("R10 top address reads zero", d, 16'h0000);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_write_timing();
    t_read_drive();
    t_walk();
    t_byte();
    t_abort();
    t_cs_release();
    t_unselected();
    t_range();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

endmodule